// File: doc/BRIEF.md
# PIO Strobe Timing Generator

This block produces the read and write strobes of an ATA programmed-I/O transfer. All timing is counted in bus clocks and comes from timing bytes that software loads. Each drive has its own bank, which holds one byte for reads and one for writes. A byte encodes the length of the active strobe pulse and the length of the recovery that follows it, each with a fixed bias. A single shared byte sets the address-setup time and the IORDY sampling delay for both drives. It also carries a read-prefetch enable bit, which has no effect on strobe timing.

A request is taken only while the generator is idle. The request carries a drive select and a direction. When it is taken, the generator captures the timing of the selected bank and runs three phases in fixed order: address setup, active strobe, recovery. It then pulses done for one clock. While the strobe is active, a drive that holds IORDY low can stretch the pulse, but only once the pulse has reached the IORDY sampling delay.

Top module: `pio_strobe_gen`

## Requirements
- R1: While reset is held and in the first clock after it, both strobes are high (inactive), busy is low and done is low.
- R2: A request is accepted at a rising edge at which busy is low. The setup phase then lasts A = misc[5:4] + 1 clocks. During setup busy is high and both strobes are high.
- R3: The active phase lasts D = timing[7:4] + 1 clocks when IORDY is high. rd_n_o is low during the active phase when dir = 0 (read), and wr_n_o is low when dir = 1 (write). The other strobe stays high, and the two strobes are never low together.
- R4: The recovery phase lasts R = timing[3:0] + 2 clocks. Busy is high and both strobes are high during recovery.
- R5: Drive select 0 uses rd_timing_i[7:0] / wr_timing_i[7:0], and drive select 1 uses rd_timing_i[15:8] / wr_timing_i[15:8]. The direction picks the read byte or the write byte.
- R6: done_o is high for exactly the one clock after the last recovery clock, and busy is low in that clock. A request held high while busy is ignored. With req held high, the gap between two strobes is R + 1 + A clocks.
- R7: At active clock k (counting from 1), the pulse ends after that clock when k ≥ D and either IORDY is high or k < Y, where Y = misc[2:1] + 2. Otherwise the strobe stays low.
- R8: IORDY has no effect at active clocks k < Y, so a pulse with D < Y ends after D clocks even with IORDY low.
- R9: The timing bytes and the shared byte are captured at acceptance. Changing them during a transfer does not alter that transfer.
- R10: misc bits 7, 6, 3 and 0 (bit 6 being the read-prefetch enable) have no effect on any output.
- R11: All-zero bytes give the minimum cycle (A=1, D=1, R=2). All-ones fields give A=4, D=16, R=17.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Transfer request, taken while idle |
| drv_i | input | SEL_W (1) | Drive select |
| dir_i | input | 1 | 0 = read, 1 = write |
| iordy_i | input | 1 | Drive ready; low stretches the active pulse |
| rd_timing_i | input | DRV_CNT*8 (16) | Per-drive read timing bytes |
| wr_timing_i | input | DRV_CNT*8 (16) | Per-drive write timing bytes |
| misc_i | input | 8 | Shared setup, IORDY delay and prefetch byte |
| rd_n_o | output | 1 | Read strobe, active low |
| wr_n_o | output | 1 | Write strobe, active low |
| busy_o | output | 1 | High from setup through recovery |
| done_o | output | 1 | One-clock pulse after recovery |

## Verification
The bench builds the block with its default of two drives. This reaches both banks and both directions, so that bank or direction mix-ups appear as strobe width errors. A behavioural model decodes the biased nibbles on its own and is compared with every output on every clock. Explicit strobe-width and strobe-to-strobe gap measurements cover the extreme encodings, IORDY stretching on either side of the sampling delay, mid-transfer changes to the timing bytes, and the prefetch bit.

// File: rtl/pio_tim_pkg.sv
// Shared types for the PIO strobe generator.
// Assumes timing bytes are 8 bits with nibble-biased fields.
package pio_tim_pkg;
    localparam int TBYTE_W = 8;
    localparam int NIB_W   = TBYTE_W / 2;
    // Counter wide enough for the longest phase (17) plus IORDY stretch headroom.
    localparam int CNT_W   = NIB_W + 1;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_ACTIVE = 2'd2,
        PH_RECOV  = 2'd3
    } pio_phase_e;

    typedef struct packed {
        logic [CNT_W-1:0] setup;
        logic [CNT_W-1:0] act;
        logic [CNT_W-1:0] recov;
        logic [CNT_W-1:0] rdy;
    } pio_lens_t;
endpackage

// File: rtl/pio_bank_mux.sv
// Picks the timing byte for the requested drive and direction.
// Assumes drv_i is always below DRV_CNT.
module pio_bank_mux
    import pio_tim_pkg::*;
#(
    parameter int DRV_CNT = 2,
    parameter int SEL_W   = 1
) (
    input  logic [DRV_CNT-1:0][TBYTE_W-1:0] rd_timing_i,
    input  logic [DRV_CNT-1:0][TBYTE_W-1:0] wr_timing_i,
    input  logic [SEL_W-1:0]                drv_i,
    input  logic                            dir_i,
    output logic [TBYTE_W-1:0]              tbyte_o
);
    // Bank by drive, byte by direction.
    always_comb begin
        tbyte_o = dir_i ? wr_timing_i[drv_i] : rd_timing_i[drv_i];
    end
endmodule

// File: rtl/pio_len_decode.sv
// Turns a timing byte and the shared byte into phase lengths in clocks.
// Assumes the fixed field positions; bits 7,6,3,0 of the shared byte are unused here.
module pio_len_decode
    import pio_tim_pkg::*;
(
    input  logic [TBYTE_W-1:0] tbyte_i,
    input  logic [TBYTE_W-1:0] misc_i,
    output pio_lens_t          lens_o
);
    logic unused_misc_bits;
    assign unused_misc_bits = ^{misc_i[7:6], misc_i[3], misc_i[0]};

    // Remove the bias of each field.
    always_comb begin
        lens_o.act   = CNT_W'(tbyte_i[TBYTE_W-1:NIB_W]) + CNT_W'(1);
        lens_o.recov = CNT_W'(tbyte_i[NIB_W-1:0])       + CNT_W'(2);
        lens_o.setup = CNT_W'(misc_i[5:4])              + CNT_W'(1);
        lens_o.rdy   = CNT_W'(misc_i[2:1])              + CNT_W'(2);
    end
endmodule

// File: rtl/pio_phase_seq.sv
// Runs setup, active and recovery phases from lengths captured at acceptance.
// Assumes lens_i holds the decoded timing of the currently requested drive.
module pio_phase_seq
    import pio_tim_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_i,
    input  logic      dir_i,
    input  logic      iordy_i,
    input  pio_lens_t lens_i,
    output logic      rd_n_o,
    output logic      wr_n_o,
    output logic      busy_o,
    output logic      done_o
);
    pio_phase_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    pio_lens_t        lens_q;
    logic             dir_q;
    logic             done_q;
    logic             act_end;

    // Active phase ends once long enough and IORDY is high or not yet sampled.
    assign act_end = (cnt_q >= lens_q.act) && (iordy_i || (cnt_q < lens_q.rdy));

    // Phase state, in-phase clock count and captured timing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PH_IDLE;
            cnt_q   <= '0;
            lens_q  <= '0;
            dir_q   <= 1'b0;
            done_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            unique case (state_q)
                PH_IDLE: begin
                    if (req_i) begin
                        lens_q  <= lens_i;
                        dir_q   <= dir_i;
                        state_q <= PH_SETUP;
                        cnt_q   <= CNT_W'(1);
                    end
                end
                PH_SETUP: begin
                    if (cnt_q == lens_q.setup) begin
                        state_q <= PH_ACTIVE;
                        cnt_q   <= CNT_W'(1);
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                PH_ACTIVE: begin
                    if (act_end) begin
                        state_q <= PH_RECOV;
                        cnt_q   <= CNT_W'(1);
                    end else if (cnt_q != '1) begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                PH_RECOV: begin
                    if (cnt_q == lens_q.recov) begin
                        state_q <= PH_IDLE;
                        cnt_q   <= '0;
                        done_q  <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                default: state_q <= PH_IDLE;
            endcase
        end
    end

    // Outputs decoded from the phase register.
    assign busy_o = (state_q != PH_IDLE);
    assign rd_n_o = !((state_q == PH_ACTIVE) && !dir_q);
    assign wr_n_o = !((state_q == PH_ACTIVE) && dir_q);
    assign done_o = done_q;

    assert_setup_len_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_SETUP && cnt_q == lens_q.setup) |=> (state_q == PH_ACTIVE));
    assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n_o && !wr_n_o));
    assert_no_early_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_ACTIVE && cnt_q < lens_q.act) |=> (state_q == PH_ACTIVE));
    assert_recov_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_RECOV && cnt_q < lens_q.recov) |=> (state_q == PH_RECOV && busy_o));
    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_RECOV && cnt_q == lens_q.recov) |=> (done_o && !busy_o));
    assert_iordy_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_ACTIVE && cnt_q >= lens_q.act && cnt_q >= lens_q.rdy && !iordy_i)
        |=> (state_q == PH_ACTIVE));
    assert_iordy_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PH_ACTIVE && cnt_q >= lens_q.act && cnt_q < lens_q.rdy)
        |=> (state_q == PH_RECOV));
    assert_lens_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != PH_IDLE) |=> (state_q == PH_IDLE || $stable(lens_q)));
endmodule

// File: rtl/pio_strobe_gen.sv
// Top of the PIO strobe generator: bank select, field decode, phase sequencer.
// Assumes synchronous inputs; IORDY must be synchronised outside this block.
module pio_strobe_gen
    import pio_tim_pkg::*;
#(
    parameter  int DRV_CNT = 2,
    localparam int SEL_W   = (DRV_CNT > 1) ? $clog2(DRV_CNT) : 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            req_i,
    input  logic [SEL_W-1:0]                drv_i,
    input  logic                            dir_i,
    input  logic                            iordy_i,
    input  logic [DRV_CNT-1:0][TBYTE_W-1:0] rd_timing_i,
    input  logic [DRV_CNT-1:0][TBYTE_W-1:0] wr_timing_i,
    input  logic [TBYTE_W-1:0]              misc_i,
    output logic                            rd_n_o,
    output logic                            wr_n_o,
    output logic                            busy_o,
    output logic                            done_o
);
    logic [TBYTE_W-1:0] tbyte;
    pio_lens_t          lens;

    pio_bank_mux #(.DRV_CNT(DRV_CNT), .SEL_W(SEL_W)) u_mux (
        .rd_timing_i (rd_timing_i),
        .wr_timing_i (wr_timing_i),
        .drv_i       (drv_i),
        .dir_i       (dir_i),
        .tbyte_o     (tbyte)
    );

    pio_len_decode u_dec (
        .tbyte_i (tbyte),
        .misc_i  (misc_i),
        .lens_o  (lens)
    );

    pio_phase_seq u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .req_i   (req_i),
        .dir_i   (dir_i),
        .iordy_i (iordy_i),
        .lens_i  (lens),
        .rd_n_o  (rd_n_o),
        .wr_n_o  (wr_n_o),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> (busy_o == 1'b0 && done_o == 1'b0 && rd_n_o && wr_n_o));
endmodule

// File: tb/test_pio_strobe_gen.sv
module test_pio_strobe_gen;
    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            req = 1'b0;
    logic [0:0]      drv = 1'b0;
    logic            dir = 1'b0;
    logic            iordy = 1'b1;
    logic [1:0][7:0] rd_tim = '0;
    logic [1:0][7:0] wr_tim = '0;
    logic [7:0]      misc = 8'h10;
    logic            rd_n, wr_n, busy, done;

    always #5 clk = ~clk;

    pio_strobe_gen i_pio_strobe_gen (
        .clk(clk), .rst_n(rst_n), .req_i(req), .drv_i(drv), .dir_i(dir),
        .iordy_i(iordy), .rd_timing_i(rd_tim), .wr_timing_i(wr_tim),
        .misc_i(misc), .rd_n_o(rd_n), .wr_n_o(wr_n), .busy_o(busy), .done_o(done)
    );

    int    vectors = 0;
    int    fails = 0;
    string cur_req = "R1";
    // Behavioural model state.
    int    m_ph = 0, m_left = 0, m_run = 0;
    int    mA = 1, mD = 1, mR = 2, mY = 2;
    bit    m_dir = 0, m_done = 0;
    // Strobe measurements.
    bit    prev_low = 0;
    int    width_cnt = 0, gap_cnt = 0, last_width = -1, last_gap = -1;

    task automatic check(input string r, input string what, input int act, input int exp);
        vectors++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d", r, what, act, exp);
        end
    endtask

    task automatic model_step();
        logic [7:0] b;
        m_done = 0;
        case (m_ph)
            0: if (req) begin
                b = dir ? wr_tim[drv] : rd_tim[drv];
                mA = ((misc >> 4) & 3) + 1;
                mY = ((misc >> 1) & 3) + 2;
                mD = (b >> 4) + 1;
                mR = (b & 15) + 2;
                m_dir = dir; m_ph = 1; m_left = mA;
            end
            1: begin m_left--; if (m_left == 0) begin m_ph = 2; m_run = 0; end end
            2: begin
                m_run++;
                if (m_run >= mD && (iordy || m_run < mY)) begin m_ph = 3; m_left = mR; end
            end
            default: begin m_left--; if (m_left == 0) begin m_ph = 0; m_done = 1; end end
        endcase
    endtask

    task automatic compare();
        bit lo;
        check(cur_req, "busy", int'(busy), int'(m_ph != 0));
        check(cur_req, "rd_n", int'(rd_n), int'(!(m_ph == 2 && !m_dir)));
        check(cur_req, "wr_n", int'(wr_n), int'(!(m_ph == 2 && m_dir)));
        check(cur_req, "done", int'(done), int'(m_done));
        lo = !rd_n || !wr_n;
        if (lo) begin
            if (!prev_low) begin last_gap = gap_cnt; width_cnt = 0; end
            width_cnt++;
        end else begin
            if (prev_low) begin last_width = width_cnt; gap_cnt = 0; end
            gap_cnt++;
        end
        prev_low = lo;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        if (!rst_n) begin m_ph = 0; m_done = 0; end
        else model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic wait_done();
        int n = 0;
        do begin tick(); n++; end while (!done && n < 200);
        if (n >= 200) check(cur_req, "done timeout", 0, 1);
    endtask

    task automatic start(input bit d, input bit w);
        drv = d; dir = w; req = 1'b1;
        tick();
        req = 1'b0;
    endtask

    task automatic b2b(input bit d0, input bit w0, input bit d1, input bit w1);
        drv = d0; dir = w0; req = 1'b1;
        tick();
        drv = d1; dir = w1;          // ignored while busy (R6)
        wait_done();
        tick();                      // second request taken in the done clock
        req = 1'b0;
        wait_done();
    endtask

    initial begin : watchdog
        #2_000_000;
        fails++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin : stim
        @(negedge clk);
        // R1: reset state
        cur_req = "R1";
        repeat (3) tick();
        check("R1", "busy in reset", int'(busy), 0);
        check("R1", "strobes in reset", int'(rd_n & wr_n), 1);
        rst_n = 1'b1;
        tick();
        check("R1", "done after reset", int'(done), 0);

        // R2 R3 R4: drive 0 read, A=2 D=4 R=7
        cur_req = "R3";
        misc = 8'h10; rd_tim[0] = 8'h35; wr_tim[0] = 8'h52;
        rd_tim[1] = 8'hA0; wr_tim[1] = 8'h1F;
        start(0, 0); wait_done(); tick();
        check("R3", "read width drv0", last_width, 4);
        // drive 0 write D=6
        start(0, 1); wait_done(); tick();
        check("R3", "write width drv0", last_width, 6);

        // R5: bank 1 selection
        cur_req = "R5";
        start(1, 0); wait_done(); tick();
        check("R5", "read width drv1", last_width, 11);
        start(1, 1); wait_done(); tick();
        check("R5", "write width drv1", last_width, 2);

        // R6 R4 R2: back-to-back, gap = R + 1 + A = 7+1+2
        cur_req = "R6";
        b2b(0, 0, 1, 0); tick();
        check("R6", "b2b gap", last_gap, 10);
        check("R6", "b2b second width", last_width, 11);

        // R11: minimum encoding
        cur_req = "R11";
        misc = 8'h00; rd_tim[0] = 8'h00;
        b2b(0, 0, 0, 0); tick();
        check("R11", "min width", last_width, 1);
        check("R11", "min gap", last_gap, 4);
        // R11: maximum encoding
        misc = 8'h30; rd_tim[0] = 8'hFF;
        b2b(0, 0, 0, 0); tick();
        check("R11", "max width", last_width, 16);
        check("R11", "max gap", last_gap, 22);

        // R7: IORDY stretch, D=3 Y=2, release in active clock 8
        cur_req = "R7";
        misc = 8'h10; rd_tim[0] = 8'h20; iordy = 1'b0;
        start(0, 0);
        while (rd_n) tick();
        repeat (7) tick();
        iordy = 1'b1;
        wait_done(); tick();
        check("R7", "stretched width", last_width, 8);

        // R8: IORDY ignored before Y, D=2 Y=5
        cur_req = "R8";
        misc = 8'h16; rd_tim[0] = 8'h10; iordy = 1'b0;
        start(0, 0); wait_done(); tick();
        iordy = 1'b1;
        check("R8", "unstretched width", last_width, 2);

        // R9: byte change mid-transfer has no effect
        cur_req = "R9";
        misc = 8'h10; rd_tim[0] = 8'h30;
        start(0, 0);
        rd_tim[0] = 8'hF0; misc = 8'h30;
        wait_done(); tick();
        check("R9", "captured width", last_width, 4);

        // R10: prefetch and spare bits ignored, gap = 3+1+2
        cur_req = "R10";
        misc = 8'hD9; rd_tim[0] = 8'h21;
        b2b(0, 0, 0, 0); tick();
        check("R10", "width with spare bits", last_width, 3);
        check("R10", "gap with spare bits", last_gap, 6);

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule